// File: doc/BRIEF.md
# Fractional sample-rate clock-enable generator

The block runs on one fast system clock and produces, for an ADC path and a DAC path, a divided tick enable and a sample-rate frame strobe. Each path has its own 3-bit divider code. The code selects a ratio of 1, 1.5, 2, 3, 4, 5.5 or 6 system clocks per tick. A half-cycle phase accumulator spreads the ticks of a fractional ratio as evenly as the clock grid allows. A frame counter counts the ticks of its path. It raises the frame strobe on every 256th tick in normal mode, or on every 272nd tick when the mode input selects 12 MHz USB-style clocking.

All outputs are single-clock enables in the system clock domain. The block creates no derived clocks. The divider codes and the mode bit are plain control pins and have no handshake. The block registers the setting it is running with. When a path's code, or the shared mode bit, differs from that stored setting, the block restarts the affected path or paths from phase zero. This prevents a short tick or a short frame when the configuration changes.

Top module: `srate_enable_gen`

## Requirements
- R1: While rst_n is low, all four outputs are low. Reset stores code 000 and normal mode as the running setting. If the inputs are 000 and 0 at reset release, no restart occurs, so adc_tick and dac_tick are high after the first clock edge.
- R2: With a path's setting unchanged for at least 2×ratio clocks, every window of 2×ratio consecutive clocks holds exactly 2 ticks. The codes map to ratios as 000=1, 001=1.5, 010=2, 011=3, 100=4, 101=5.5 and 110=6.
- R3: Count the first clock edge after a restart edge as edge 1. The k-th tick of a path is then high after edge ceil(k×ratio), and the tick is low after every other edge.
- R4: Code 111 behaves exactly like code 000 (ratio 1, tick high on every clock).
- R5: The ADC and DAC paths are independent. Changing one path's code has no effect on the other path's outputs.
- R6: With the mode input at 0, the frame strobe of a path is high together with every 256th tick after a restart and low at all other times. In steady state, consecutive strobes are therefore 256×ratio clocks apart.
- R7: With the mode input at 1, the frame strobe is high with every 272nd tick. Consecutive strobes are 272×ratio clocks apart.
- R8: A clock edge at which a path's code input differs from its stored code restarts that path. The edge clears the path's phase and frame count and drives its tick low. Timing from R3 begins anew.
- R9: A clock edge at which the mode input differs from the stored mode restarts both paths in the same way.
- R10: A frame strobe is high only while the tick of its own path is high, and it is never high for two consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| adc_div_code | input | 3 | ADC path divider code |
| dac_div_code | input | 3 | DAC path divider code |
| usb_mode | input | 1 | 0: 256 ticks per frame, 1: 272 ticks per frame |
| adc_tick | output | 1 | ADC divided tick enable |
| adc_frame | output | 1 | ADC sample-rate strobe |
| dac_tick | output | 1 | DAC divided tick enable |
| dac_frame | output | 1 | DAC sample-rate strobe |

## Verification
The hardest case to reach from the ports is a frame that spans a long steady run at each of the largest ratios. A strobe pair at ratio 6 in USB mode is 1632 clocks apart. The bench therefore holds every code in both modes long enough for two strobes per path, and it pairs codes in opposite order so that both paths sweep all ratios in the same run. It then changes one path's code every few dozen clocks while the other keeps running, and it toggles the mode mid-frame, to confirm that each restart lands on the intended edge.

// File: rtl/srate_pkg.sv
package srate_pkg;
  localparam int CODE_W = 3;
  localparam int LIM_W  = 5;

  // limit in half-cycles, i.e. twice the divide ratio
  function automatic logic [LIM_W-1:0] half_limit(input logic [CODE_W-1:0] code);
    case (code)
      3'd0:    half_limit = 5'd2;
      3'd1:    half_limit = 5'd3;
      3'd2:    half_limit = 5'd4;
      3'd3:    half_limit = 5'd6;
      3'd4:    half_limit = 5'd8;
      3'd5:    half_limit = 5'd11;
      3'd6:    half_limit = 5'd12;
      default: half_limit = 5'd2;
    endcase
  endfunction
endpackage

// File: rtl/srate_phase_acc.sv
module srate_phase_acc #(
  parameter int LIM_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [LIM_W-1:0] limit,
  output logic             tick
);
  localparam int ACC_W = LIM_W + 1;

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] sum;
  logic [ACC_W-1:0] lim_ext;
  logic             hit;

  assign lim_ext = {1'b0, limit};
  assign sum     = acc_q + ACC_W'(2);
  assign hit     = (sum >= lim_ext);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      acc_q <= '0;
      tick  <= 1'b0;
    end else begin
      tick  <= hit;
      acc_q <= hit ? (sum - lim_ext) : sum;
    end
  end

  AST_ACC_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q < lim_ext); // R2

  AST_UNITY_EVERY_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart && limit == LIM_W'(2)) |=> tick); // R4
endmodule

// File: rtl/srate_frame_ctr.sv
module srate_frame_ctr #(
  parameter int NORM_LEN = 256,
  parameter int USB_LEN  = 272
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic usb,
  input  logic tick,
  output logic frame
);
  localparam int MAX_LEN = (NORM_LEN > USB_LEN) ? NORM_LEN : USB_LEN;
  localparam int CNT_W   = $clog2(MAX_LEN);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_idx;
  logic             at_last;

  assign last_idx = usb ? CNT_W'(USB_LEN - 1) : CNT_W'(NORM_LEN - 1);
  assign at_last  = (cnt_q == last_idx);
  assign frame    = tick && at_last;

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= at_last ? '0 : cnt_q + CNT_W'(1);
    end
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= last_idx); // R6

  AST_FRAME_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
    (frame && !restart) |=> (cnt_q == '0)); // R7
endmodule

// File: rtl/srate_path.sv
module srate_path
  import srate_pkg::*;
#(
  parameter int NORM_LEN = 256,
  parameter int USB_LEN  = 272
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] code,
  input  logic              usb,
  output logic              tick,
  output logic              frame
);
  logic [CODE_W-1:0] code_q;
  logic              mode_q;
  logic              restart;
  logic [LIM_W-1:0]  limit;

  assign restart = (code != code_q) || (usb != mode_q);
  assign limit   = half_limit(code_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q <= '0;
      mode_q <= 1'b0;
    end else begin
      code_q <= code;
      mode_q <= usb;
    end
  end

  srate_phase_acc #(.LIM_W(LIM_W)) u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .limit   (limit),
    .tick    (tick)
  );

  srate_frame_ctr #(.NORM_LEN(NORM_LEN), .USB_LEN(USB_LEN)) u_frame (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .usb     (mode_q),
    .tick    (tick),
    .frame   (frame)
  );

  AST_RESTART_QUIETS: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !tick); // R8
endmodule

// File: rtl/srate_enable_gen.sv
module srate_enable_gen
  import srate_pkg::*;
#(
  parameter int NORM_LEN = 256,
  parameter int USB_LEN  = 272
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] adc_div_code,
  input  logic [CODE_W-1:0] dac_div_code,
  input  logic              usb_mode,
  output logic              adc_tick,
  output logic              adc_frame,
  output logic              dac_tick,
  output logic              dac_frame
);
  localparam int NPATH = 2;

  logic [CODE_W-1:0] code_arr  [NPATH];
  logic              tick_arr  [NPATH];
  logic              frame_arr [NPATH];

  assign code_arr[0] = adc_div_code;
  assign code_arr[1] = dac_div_code;

  for (genvar p = 0; p < NPATH; p++) begin : g_path
    srate_path #(.NORM_LEN(NORM_LEN), .USB_LEN(USB_LEN)) u_path (
      .clk   (clk),
      .rst_n (rst_n),
      .code  (code_arr[p]),
      .usb   (usb_mode),
      .tick  (tick_arr[p]),
      .frame (frame_arr[p])
    );
  end

  assign adc_tick  = tick_arr[0];
  assign adc_frame = frame_arr[0];
  assign dac_tick  = tick_arr[1];
  assign dac_frame = frame_arr[1];

  AST_MODE_RESTARTS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    (usb_mode != $past(usb_mode)) |=> (!adc_tick && !dac_tick)); // R9

  AST_FRAME_NOT_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_frame || dac_frame) |=> !(adc_frame && $past(adc_frame)) && !(dac_frame && $past(dac_frame))); // R10
endmodule

// File: tb/srate_enable_gen_test.sv
module srate_enable_gen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] adc_code = 3'd0;
  logic [2:0] dac_code = 3'd0;
  logic       usb = 1'b0;
  logic       adc_tick, adc_frame, dac_tick, dac_frame;

  int checks = 0;
  int errors = 0;
  int cycle = 0;
  string phase_tag = "R3";

  always #2 clk = ~clk;

  srate_enable_gen uut (
    .clk(clk), .rst_n(rst_n),
    .adc_div_code(adc_code), .dac_div_code(dac_code), .usb_mode(usb),
    .adc_tick(adc_tick), .adc_frame(adc_frame),
    .dac_tick(dac_tick), .dac_frame(dac_frame)
  );

  function automatic int lim_of(input int c);
    case (c)
      0: return 2;  1: return 3;  2: return 4;  3: return 6;
      4: return 8;  5: return 11; 6: return 12; default: return 2;
    endcase
  endfunction

  // reference state per path (0 = ADC, 1 = DAC)
  int m_acc [2];
  int m_tk  [2];
  int m_cnt [2];
  int m_cq  [2];
  int m_mq  [2];
  int m_age [2];
  int m_modechg [2];
  int tick_hist [2][$];
  int since_frame [2];
  int have_frame [2];
  int prev_frame [2];

  task automatic check(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp, cycle);
    end
  endtask

  function automatic int in_code(input int p);
    return (p == 0) ? int'(adc_code) : int'(dac_code);
  endfunction

  always @(posedge clk) begin
    cycle++;
    for (int p = 0; p < 2; p++) begin
      int lim, len, s;
      if (!rst_n) begin
        m_acc[p] = 0; m_tk[p] = 0; m_cnt[p] = 0; m_cq[p] = 0; m_mq[p] = 0;
        m_age[p] = 0; m_modechg[p] = 0;
      end else if (in_code(p) != m_cq[p] || int'(usb) != m_mq[p]) begin
        m_modechg[p] = (int'(usb) != m_mq[p]) ? 1 : 0;
        m_acc[p] = 0; m_tk[p] = 0; m_cnt[p] = 0;
        m_cq[p] = in_code(p); m_mq[p] = int'(usb); m_age[p] = 0;
      end else begin
        lim = lim_of(m_cq[p]);
        len = m_mq[p] ? 272 : 256;
        if (m_tk[p] != 0) m_cnt[p] = (m_cnt[p] == len - 1) ? 0 : m_cnt[p] + 1;
        s = m_acc[p] + 2;
        if (s >= lim) begin m_tk[p] = 1; m_acc[p] = s - lim; end
        else begin m_tk[p] = 0; m_acc[p] = s; end
        m_age[p]++;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      for (int p = 0; p < 2; p++) begin
        int tk, fr, len, lim, exp_fr, sum;
        string ttag, ftag;
        tk  = (p == 0) ? int'(adc_tick) : int'(dac_tick);
        fr  = (p == 0) ? int'(adc_frame) : int'(dac_frame);
        len = m_mq[p] ? 272 : 256;
        lim = lim_of(m_cq[p]);
        exp_fr = (m_tk[p] != 0 && m_cnt[p] == len - 1) ? 1 : 0;
        ttag = phase_tag;
        if (m_age[p] == 0 && m_modechg[p] != 0) ttag = "R9";
        else if (m_age[p] == 0 && phase_tag != "R5") ttag = "R8";
        else if (phase_tag == "R3" && m_cq[p] == 7) ttag = "R4";
        ftag = (ttag == "R3" || ttag == "R4") ? (m_mq[p] ? "R7" : "R6") : ttag;
        check(ttag, tk, m_tk[p], (p == 0) ? "adc_tick" : "dac_tick");
        check(ftag, fr, exp_fr, (p == 0) ? "adc_frame" : "dac_frame");
        // R10 pulse shape
        if (fr != 0) begin
          check("R10", tk, 1, "tick under frame");
          check("R10", prev_frame[p], 0, "frame on previous clock");
        end
        prev_frame[p] = fr;
        // R2 window count
        if (m_age[p] == 0) tick_hist[p].delete();
        tick_hist[p].push_back(tk);
        if (tick_hist[p].size() > lim) void'(tick_hist[p].pop_front());
        if (m_age[p] >= lim && tick_hist[p].size() == lim) begin
          sum = 0;
          foreach (tick_hist[p][i]) sum += tick_hist[p][i];
          check("R2", sum, 2, "ticks per 2x ratio window");
        end
        // R6/R7 frame spacing
        if (m_age[p] == 0) begin have_frame[p] = 0; since_frame[p] = 0; end
        else since_frame[p]++;
        if (fr != 0) begin
          if (have_frame[p] != 0)
            check(m_mq[p] ? "R7" : "R6", since_frame[p], len * lim / 2, "frame spacing");
          have_frame[p] = 1;
          since_frame[p] = 0;
        end
      end
    end
  end

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    for (int p = 0; p < 2; p++) begin
      have_frame[p] = 0; since_frame[p] = 0; prev_frame[p] = 0;
    end
    repeat (5) @(posedge clk);
    @(negedge clk);
    check("R1", int'(adc_tick | adc_frame | dac_tick | dac_frame), 0, "outputs in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", int'(adc_tick & dac_tick), 1, "ticks after first edge");
    // sweep all codes in both modes, codes paired in opposite order
    for (int m = 0; m < 2; m++) begin
      usb = m[0];
      for (int i = 0; i < 7; i++) begin
        int mx;
        adc_code = 3'(i);
        dac_code = 3'(6 - i);
        mx = (lim_of(i) > lim_of(6 - i)) ? lim_of(i) : lim_of(6 - i);
        run((m ? 272 : 256) * mx + 20);
      end
    end
    // reserved code
    usb = 1'b0;
    adc_code = 3'd7; dac_code = 3'd7;
    run(256 * 2 + 10);
    // independence: DAC code hops while ADC keeps running
    phase_tag = "R5";
    adc_code = 3'd5;
    run(30);
    for (int k = 0; k < 16; k++) begin
      dac_code = 3'(k % 7);
      run(37);
    end
    // restarts on code change of one path
    phase_tag = "R8";
    for (int k = 0; k < 10; k++) begin
      adc_code = 3'((k * 3) % 8);
      run(41);
    end
    // mode toggles mid-frame
    phase_tag = "R9";
    for (int k = 0; k < 6; k++) begin
      usb = ~usb;
      run(53);
    end
    phase_tag = "R3";
    usb = 1'b1; adc_code = 3'd1; dac_code = 3'd5;
    run(272 * 11 + 20);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule